// File: doc/BRIEF.md
# Volatile Sector Protection Command Sequencer

This block watches the byte-wide write cycles on a flash-style bus and decodes command sequences guarded by an unlock prefix. A three-write unlock prefix picks one of two command sets. The volatile set holds one protect flag per sector. The lock set holds a single global lock flag. Inside a set, a two-write operation changes a flag, and a status read returns a fixed protected or unprotected code. A two-write exit sequence returns the block to normal array read mode. Until that exit is written, the block stays inside the set.

The per-sector protect flags leave the block as a write-protect vector, which the array's program and erase control uses. The sector is chosen by the address bits from bit 16 up to the top bit. Those bits have no effect on unlock, entry and exit writes.

Top module: `sect_prot_seq`

## Requirements
- R1: After reset every sector is unprotected (`wp` all zero), the lock flag is clear, and the block is in read mode, where a read returns FFh.
- R2: The writes (addr[15:0]=0AAAh, AAh), (0555h, 55h), (0AAAh, E0h) enter the volatile set. The writes 0AAAh/AAh, 0555h/55h, 0AAAh/50h enter the lock set.
- R3: Any write that does not match the next step of an unlock prefix returns the block to read mode. Writes of A0h/00h that follow it then leave `wp` unchanged, and reads return FFh.
- R4: In the volatile set, a write of A0h to any address followed by a write of 00h sets the protect flag of the sector given by addr[ADDR_W-1:16] of that second write. No other sector changes.
- R5: In the volatile set, a write of A0h followed by a write of 01h clears the protect flag of the addressed sector.
- R6: In the volatile set, a write of A0h followed by any data other than 00h or 01h changes no flag. The set stays active.
- R7: A read in the volatile set returns, one clock later, 00h if the sector at addr[ADDR_W-1:16] is protected and 01h if it is not.
- R8: In the lock set, A0h followed by 00h sets the lock flag. It stays set until reset. A read in the lock set returns 00h when the flag is set and 01h when it is clear.
- R9: A write of 90h followed by a write of 00h, to any address, leaves either set and returns to read mode. If the write after 90h carries other data, the set stays active. In read mode, writes of A0h/00h have no effect on `wp`.
- R10: The sector bits addr[ADDR_W-1:16] are ignored on unlock, entry and exit writes.
- R11: Protect flags keep their values across entry into and exit from the sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address; bits [ADDR_W-1:16] select the sector |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rd_data` updates on the next clock |
| rd_data | output | 8 | Read data: FFh in read mode, status code inside a set |
| wp | output | 2**(ADDR_W-16) | Per-sector write protect, 1 = protected |

## Verification
The hardest cases to reach are the partial sequences. These are an unlock prefix broken at its second or third write, an operation prefix (A0h) followed by data that means nothing, and an exit prefix (90h) followed by non-zero data. Each leaves the sequencer in a different state that the ports do not show directly. The stimulus writes each broken sequence and then a follow-up operation or read. A behavioural reference model runs on every clock, so any stray state left behind shows up as a difference in `wp` or `rd_data`.

// File: rtl/spcs_pkg.sv
package spcs_pkg;
   typedef enum logic [3:0] {
      ST_READ, ST_UNL1, ST_UNL2,
      ST_VSET, ST_VOP, ST_VEXIT,
      ST_LSET, ST_LOP, ST_LEXIT
   } seq_state_t;

   typedef enum logic [1:0] {RM_ARRAY, RM_VOL, RM_LOCK} rd_mode_t;

   localparam logic [11:0] ADR_FIRST  = 12'hAAA;
   localparam logic [11:0] ADR_SECOND = 12'h555;
   localparam logic [7:0]  D_UNL1   = 8'hAA;
   localparam logic [7:0]  D_UNL2   = 8'h55;
   localparam logic [7:0]  D_VOLSET = 8'hE0;
   localparam logic [7:0]  D_LCKSET = 8'h50;
   localparam logic [7:0]  D_OP     = 8'hA0;
   localparam logic [7:0]  D_EXIT   = 8'h90;
   localparam logic [7:0]  D_ZERO   = 8'h00;
   localparam logic [7:0]  D_ONE    = 8'h01;
   localparam logic [7:0]  D_PROT   = 8'h00;
   localparam logic [7:0]  D_UNPROT = 8'h01;
   localparam logic [7:0]  D_ARRAY  = 8'hFF;
endpackage

// File: rtl/spcs_seq.sv
module spcs_seq
   import spcs_pkg::*;
#(
   parameter int CMD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMD_W-1:0] cmd_addr,
   input  logic [7:0]       wdata,
   output logic             vol_set,
   output logic             vol_clr,
   output logic             lock_set,
   output rd_mode_t         rd_mode
);
   localparam logic [CMD_W-1:0] A_FIRST  = CMD_W'(ADR_FIRST);
   localparam logic [CMD_W-1:0] A_SECOND = CMD_W'(ADR_SECOND);

   seq_state_t st, nxt;
   logic at_first, at_second;

   assign at_first  = (cmd_addr == A_FIRST);
   assign at_second = (cmd_addr == A_SECOND);

   always_comb begin
      nxt      = st;
      vol_set  = 1'b0;
      vol_clr  = 1'b0;
      lock_set = 1'b0;
      if (wr_en) begin
         case (st)
            ST_READ:  if (at_first && wdata == D_UNL1) nxt = ST_UNL1;
            ST_UNL1:  nxt = (at_second && wdata == D_UNL2) ? ST_UNL2 : ST_READ;
            ST_UNL2: begin
               if (at_first && wdata == D_VOLSET)      nxt = ST_VSET;
               else if (at_first && wdata == D_LCKSET) nxt = ST_LSET;
               else                                    nxt = ST_READ;
            end
            ST_VSET: begin
               if (wdata == D_OP)        nxt = ST_VOP;
               else if (wdata == D_EXIT) nxt = ST_VEXIT;
            end
            ST_VOP: begin
               nxt     = ST_VSET;
               vol_set = (wdata == D_ZERO);
               vol_clr = (wdata == D_ONE);
            end
            ST_VEXIT: nxt = (wdata == D_ZERO) ? ST_READ : ST_VSET;
            ST_LSET: begin
               if (wdata == D_OP)        nxt = ST_LOP;
               else if (wdata == D_EXIT) nxt = ST_LEXIT;
            end
            ST_LOP: begin
               nxt      = ST_LSET;
               lock_set = (wdata == D_ZERO);
            end
            ST_LEXIT: nxt = (wdata == D_ZERO) ? ST_READ : ST_LSET;
            default:  nxt = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_READ;
      else        st <= nxt;
   end

   always_comb begin
      case (st)
         ST_VSET, ST_VOP, ST_VEXIT: rd_mode = RM_VOL;
         ST_LSET, ST_LOP, ST_LEXIT: rd_mode = RM_LOCK;
         default:                   rd_mode = RM_ARRAY;
      endcase
   end

   assert_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_UNL1 && wr_en && !(at_second && wdata == D_UNL2)) |=> rd_mode == RM_ARRAY);
   assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_UNL2 && wr_en && at_first && wdata == D_VOLSET) |=> rd_mode == RM_VOL);
   assert_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_VEXIT || st == ST_LEXIT) && wr_en && wdata == D_ZERO) |=> rd_mode == RM_ARRAY);
   assert_one_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vol_set, vol_clr, lock_set}));
endmodule

// File: rtl/spcs_bits.sv
module spcs_bits #(
   parameter int SECT_BITS = 3,
   localparam int NUM_SECT = 1 << SECT_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vol_set,
   input  logic                 vol_clr,
   input  logic                 lock_set,
   input  logic [SECT_BITS-1:0] sect_sel,
   output logic [NUM_SECT-1:0]  prot,
   output logic                 lock_q
);
   for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      logic hit;
      assign hit = (sect_sel == SECT_BITS'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              prot[i] <= 1'b0;
         else if (hit && vol_set) prot[i] <= 1'b1;
         else if (hit && vol_clr) prot[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_q <= 1'b0;
      else if (lock_set) lock_q <= 1'b1;
   end

   assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vol_set |=> prot[$past(sect_sel)]);
   assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vol_clr |=> !prot[$past(sect_sel)]);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(vol_set || vol_clr) |=> $stable(prot));
   assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
endmodule

// File: rtl/spcs_rd.sv
module spcs_rd
   import spcs_pkg::*;
#(
   parameter int SECT_BITS = 3,
   localparam int NUM_SECT = 1 << SECT_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  rd_mode_t             rd_mode,
   input  logic [NUM_SECT-1:0]  prot,
   input  logic                 lock_q,
   input  logic [SECT_BITS-1:0] sect_sel,
   output logic [7:0]           rd_data
);
   logic [7:0] rd_nxt;

   always_comb begin
      case (rd_mode)
         RM_VOL:  rd_nxt = prot[sect_sel] ? D_PROT : D_UNPROT;
         RM_LOCK: rd_nxt = lock_q ? D_PROT : D_UNPROT;
         default: rd_nxt = D_ARRAY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= D_ARRAY;
      else if (rd_en) rd_data <= rd_nxt;
   end

   assert_status_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_mode == RM_VOL) |=> (rd_data == D_PROT || rd_data == D_UNPROT));
   assert_array_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_mode == RM_ARRAY) |=> rd_data == D_ARRAY);
   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/sect_prot_seq.sv
module sect_prot_seq
   import spcs_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int SECT_LSB = 16,
   localparam int SECT_BITS = ADDR_W - SECT_LSB,
   localparam int NUM_SECT  = 1 << SECT_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          wdata,
   input  logic                wr_en,
   input  logic                rd_en,
   output logic [7:0]          rd_data,
   output logic [NUM_SECT-1:0] wp
);
   if (SECT_LSB < 12) begin : g_bad_lsb
      $error("SECT_LSB must leave room for the 12-bit unlock addresses");
   end
   if (SECT_BITS < 1 || SECT_BITS > 10) begin : g_bad_sect
      $error("sector field width must be 1 to 10 bits");
   end

   logic                 vol_set, vol_clr, lock_set, lock_q;
   logic [SECT_BITS-1:0] sect_sel;
   rd_mode_t             rd_mode;

   assign sect_sel = addr[ADDR_W-1:SECT_LSB];

   spcs_seq #(.CMD_W(SECT_LSB)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .cmd_addr(addr[SECT_LSB-1:0]), .wdata(wdata),
      .vol_set(vol_set), .vol_clr(vol_clr), .lock_set(lock_set),
      .rd_mode(rd_mode)
   );

   spcs_bits #(.SECT_BITS(SECT_BITS)) u_bits (
      .clk(clk), .rst_n(rst_n), .vol_set(vol_set), .vol_clr(vol_clr),
      .lock_set(lock_set), .sect_sel(sect_sel), .prot(wp), .lock_q(lock_q)
   );

   spcs_rd #(.SECT_BITS(SECT_BITS)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_mode(rd_mode),
      .prot(wp), .lock_q(lock_q), .sect_sel(sect_sel), .rd_data(rd_data)
   );

   assert_no_change_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode == RM_ARRAY) |=> $stable(wp));
endmodule

// File: tb/tb_sect_prot_seq.sv
module tb_sect_prot_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [18:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic [7:0]  wp;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   sect_prot_seq dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                      .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .wp(wp));

   // behavioural reference: 0 read,1-2 unlock,3 vol,4 vol op,5 vol exit,6 lock,7 lock op,8 lock exit
   int         m_st;
   logic [7:0] m_prot;
   logic       m_lock;
   logic [7:0] m_rd;
   bit         m_valid = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_st = 0; m_prot = '0; m_lock = 0; m_rd = 8'hFF; m_valid = 1;
      end else begin
         if (rd_en) begin
            if (m_st >= 3 && m_st <= 5)      m_rd = m_prot[addr[18:16]] ? 8'h00 : 8'h01;
            else if (m_st >= 6)              m_rd = m_lock ? 8'h00 : 8'h01;
            else                             m_rd = 8'hFF;
         end
         if (wr_en) begin
            case (m_st)
               0: m_st = (addr[15:0] == 16'h0AAA && wdata == 8'hAA) ? 1 : 0;
               1: m_st = (addr[15:0] == 16'h0555 && wdata == 8'h55) ? 2 : 0;
               2: m_st = (addr[15:0] != 16'h0AAA) ? 0 : (wdata == 8'hE0) ? 3 : (wdata == 8'h50) ? 6 : 0;
               3: m_st = (wdata == 8'hA0) ? 4 : (wdata == 8'h90) ? 5 : 3;
               4: begin
                  if (wdata == 8'h00) m_prot[addr[18:16]] = 1'b1;
                  if (wdata == 8'h01) m_prot[addr[18:16]] = 1'b0;
                  m_st = 3;
               end
               5: m_st = (wdata == 8'h00) ? 0 : 3;
               6: m_st = (wdata == 8'hA0) ? 7 : (wdata == 8'h90) ? 8 : 6;
               7: begin if (wdata == 8'h00) m_lock = 1'b1; m_st = 6; end
               default: m_st = (wdata == 8'h00) ? 0 : 6;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && m_valid) begin
         checks++;
         if (wp !== m_prot) begin
            errors++;
            $display("FAIL %s per-cycle wp: actual %h expected %h", cur_req, wp, m_prot);
         end
         checks++;
         if (rd_data !== m_rd) begin
            errors++;
            $display("FAIL %s per-cycle rd_data: actual %h expected %h", cur_req, rd_data, m_rd);
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [18:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [18:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic unlock(input logic [2:0] junk, input logic [7:0] setcode);
      wr({junk, 16'h0AAA}, 8'hAA);
      wr({~junk, 16'h0555}, 8'h55);
      wr({junk, 16'h0AAA}, setcode);
   endtask

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1 wp after reset", wp, 8'h00);
      rd(19'h0, r); chk("R1 read mode after reset", r, 8'hFF);

      cur_req = "R2";
      unlock(3'd0, 8'hE0);
      rd({3'd3, 16'h0}, r); chk("R2 volatile set entered, sector 3 unprotected", r, 8'h01);

      cur_req = "R4";
      wr(19'h0, 8'hA0); wr({3'd3, 16'h1234}, 8'h00);
      chk("R4 only sector 3 protected", wp, 8'h08);
      cur_req = "R7";
      rd({3'd3, 16'h0}, r); chk("R7 protected status", r, 8'h00);
      rd({3'd2, 16'h0}, r); chk("R7 unprotected status", r, 8'h01);
      wr({3'd5, 16'h0}, 8'hA0); wr({3'd7, 16'h0}, 8'h00);
      chk("R4 sector 7 set", wp, 8'h88);

      cur_req = "R5";
      wr(19'h0, 8'hA0); wr({3'd3, 16'h0}, 8'h01);
      chk("R5 sector 3 cleared", wp, 8'h80);

      cur_req = "R6";
      wr(19'h0, 8'hA0); wr({3'd7, 16'h0}, 8'h7F);
      chk("R6 junk operation data", wp, 8'h80);
      rd({3'd7, 16'h0}, r); chk("R6 set still active after junk op", r, 8'h00);

      cur_req = "R9";
      wr(19'h0, 8'h90); wr(19'h0, 8'h12);
      rd({3'd6, 16'h0}, r); chk("R9 exit with non-zero data keeps set", r, 8'h01);
      wr({3'd4, 16'h0}, 8'h90); wr({3'd2, 16'h0}, 8'h00);
      rd({3'd7, 16'h0}, r); chk("R9 exit gives array read", r, 8'hFF);
      wr(19'h0, 8'hA0); wr({3'd1, 16'h0}, 8'h00);
      chk("R9 operation ignored in read mode", wp, 8'h80);
      cur_req = "R11";
      chk("R11 protect flags kept after exit", wp, 8'h80);

      cur_req = "R3";
      wr(19'h0AAA, 8'hAA); wr(19'h0554, 8'h55); wr(19'h0AAA, 8'hE0);
      wr(19'h0, 8'hA0); wr({3'd0, 16'h0}, 8'h00);
      chk("R3 second-step break, no entry", wp, 8'h80);
      rd(19'h0, r); chk("R3 read mode after break", r, 8'hFF);
      wr(19'h0AAA, 8'hAA); wr(19'h0555, 8'h55); wr(19'h0AAA, 8'h33);
      wr(19'h0, 8'hA0); wr({3'd0, 16'h0}, 8'h00);
      chk("R3 third-step break, no entry", wp, 8'h80);

      cur_req = "R10";
      unlock(3'd5, 8'hE0);
      wr({3'd6, 16'h0}, 8'hA0); wr({3'd0, 16'h0}, 8'h00);
      chk("R10 entry with sector bits set", wp, 8'h81);
      wr({3'd3, 16'h0}, 8'h90); wr({3'd6, 16'h0}, 8'h00);
      rd({3'd0, 16'h0}, r); chk("R10 exit with sector bits set", r, 8'hFF);

      cur_req = "R8";
      unlock(3'd0, 8'h50);
      rd(19'h0, r); chk("R8 lock clear status", r, 8'h01);
      wr(19'h0, 8'hA0); wr(19'h0, 8'h00);
      rd(19'h0, r); chk("R8 lock set status", r, 8'h00);
      chk("R8 lock op leaves wp", wp, 8'h81);
      wr(19'h0, 8'h90); wr(19'h0, 8'h00);
      unlock(3'd0, 8'h50);
      rd(19'h0, r); chk("R8 lock stays set", r, 8'h00);
      wr(19'h0, 8'h90); wr(19'h0, 8'h00);

      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R1 wp cleared by reset", wp, 8'h00);
      unlock(3'd0, 8'h50);
      rd(19'h0, r); chk("R1 lock clear after reset", r, 8'h01);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule